// File: doc/BRIEF.md
# Extended 64-bit Integer ALU

This block is a single-issue 64-bit integer execution unit. Each cycle it may accept one operation, given as a 7-bit operation code, two 64-bit source operands and a valid strobe. One clock later it presents the 64-bit result, a matching valid strobe and a branch-taken flag. The three most significant opcode bits pick an operation family. The families are: shift and single-bit manipulation, 32-bit word arithmetic with sign extension, add forms, subtract and compare, plain bitwise logic, bitwise logic reduced to a narrow result, and branch condition evaluation.

The add family covers several variants. Some scale one operand by a left shift or a logical right shift before the add. Some first zero-extend the low word of that operand. Some use only its least significant bit. Some return only a narrow slice of the sum. Branch operations produce no data result. The comparison kind comes from opcode bits [3:2] and the inversion from bit 1, and the outcome appears only on the taken flag. An opcode that is not listed below produces a zero result and a clear taken flag.

Top module: `ix_alu`

## Requirements
- R1: Results are registered with exactly one cycle of latency. `out_valid` equals `in_valid` of the previous cycle. While reset is held, and in the cycle after an idle input, `out_valid`, `out_result` and `out_taken` are all zero, whatever the opcode or operands.
- R2: 64-bit shifts and rotates take their amount from `in_src2[5:0]`. The opcodes are sll 0x01, srl 0x05, sra 0x07 (arithmetic), rol 0x09 and ror 0x0B. Opcode 0x00 shifts the zero-extended `in_src1[31:0]` left.
- R3: Single-bit operations index with `in_src2[5:0]`. 0x02 clears the selected bit of `in_src1`, 0x03 sets it, and 0x06 returns that bit alone in bit 0.
- R4: Word operations compute on the low 32 bits and sign-extend result bit 31 to 64 bits. The opcodes are addw 0x10, subw 0x12, sllw 0x18, srlw 0x19 (logical, on `in_src1[31:0]` only), sraw 0x1A, rolw 0x1C and rorw 0x1D. Word shift and rotate amounts are `in_src2[4:0]`.
- R5: Opcode 0x11 adds `in_src1[0]` to `in_src2` and sign-extends bit 31 of the sum. Opcodes 0x14, 0x15, 0x16 and 0x17 return a slice of `in_src1+in_src2`: bit 0, bits [7:0], bits [15:0] zero-extended, and bits [15:0] sign-extended.
- R6: Opcode 0x20 adds the zero-extended `in_src1[31:0]` to `in_src2`. 0x21 is a full add, and 0x22 adds `in_src1[0]` to `in_src2`. Opcodes 0x24 to 0x27 add `in_src2` to `in_src1` shifted right logically by 29, 30, 31 and 32.
- R7: Scaled adds return `(in_src1 << k) + in_src2`. k=1 uses 0x29, k=2 uses 0x2B, k=3 uses 0x2D and k=4 uses 0x2F. The opcodes 0x28, 0x2A and 0x2C do the same for k=1, 2 and 3 on the zero-extended `in_src1[31:0]`.
- R8: 0x30 returns `in_src1-in_src2`. 0x31 returns an unsigned less-than as 0/1, and 0x32 returns the signed less-than. 0x34 and 0x35 return the unsigned maximum and minimum, and 0x36 and 0x37 return the signed maximum and minimum.
- R9: Bitwise logic uses these opcodes: 0x40 and, 0x41 and-not (`a & ~b`), 0x42 or, 0x43 or-not, 0x44 xor and 0x45 xnor. Opcode 0x46 replaces every nonzero byte of `in_src1` with 0xFF and every zero byte with 0x00.
- R10: Opcodes 0x60 to 0x67 apply a base logic op picked by opcode bits [2:1]: 00 and, 01 or, 10 xor, 11 byte-spread of `in_src1`. When bit 0 is 0 only bit 0 of that result is kept. When bit 0 is 1 its low 16 bits are zero-extended.
- R11: Branch opcodes are 0x70 (equal), 0x72 (not equal), 0x78 (signed less), 0x7A (signed greater-or-equal), 0x7C (unsigned less) and 0x7E (unsigned greater-or-equal). `out_taken` is the comparison outcome XORed with opcode bit 1, and `out_result` is zero for them. No other opcode ever raises `out_taken`.
- R12: Every opcode not listed in R2 to R11 produces a zero result and a clear taken flag. This includes the whole 0x50 to 0x5F range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 7 | Operation code |
| in_src1 | input | 64 | First source operand |
| in_src2 | input | 64 | Second source operand, shift amount or bit index |
| out_valid | output | 1 | Result of the previous cycle's operation is present |
| out_result | output | 64 | Registered data result |
| out_taken | output | 1 | Registered branch condition outcome |

## Verification
Because the unit is fully pipelined, in one cycle the output register can present a branch outcome while the compare path is already computing the data result of the next, unrelated operation. The bench issues operations on every cycle with no gaps. The table places taken branches directly before a signed minimum and an unsigned maximum. The opcode sweep also steps from each branch code into its neighbours. Each cycle is judged on all three outputs together. The taken flag must fall in exactly the cycle the following non-branch result appears, and a branch must never leave a stale nonzero result behind.

// File: rtl/ix_alu_pkg.sv
package ix_alu_pkg;

    typedef logic [6:0] opc_t;

    // operation families, opcode bits [6:4]
    localparam logic [2:0] FAM_SHIFT = 3'b000;
    localparam logic [2:0] FAM_WORD  = 3'b001;
    localparam logic [2:0] FAM_ADD   = 3'b010;
    localparam logic [2:0] FAM_CMP   = 3'b011;
    localparam logic [2:0] FAM_LOGIC = 3'b100;
    localparam logic [2:0] FAM_RSVD  = 3'b101;
    localparam logic [2:0] FAM_NARLG = 3'b110;
    localparam logic [2:0] FAM_BR    = 3'b111;

    // shift and single-bit family
    localparam opc_t OP_SLL_UW   = 7'h00;
    localparam opc_t OP_SLL      = 7'h01;
    localparam opc_t OP_BITCLR   = 7'h02;
    localparam opc_t OP_BITSET   = 7'h03;
    localparam opc_t OP_SRL      = 7'h05;
    localparam opc_t OP_BITGET   = 7'h06;
    localparam opc_t OP_SRA      = 7'h07;
    localparam opc_t OP_ROTL     = 7'h09;
    localparam opc_t OP_ROTR     = 7'h0B;

    // word family
    localparam opc_t OP_ADDW     = 7'h10;
    localparam opc_t OP_ODDADDW  = 7'h11;
    localparam opc_t OP_SUBW     = 7'h12;
    localparam opc_t OP_SUM_BIT  = 7'h14;
    localparam opc_t OP_SUM_BYTE = 7'h15;
    localparam opc_t OP_SUM_ZH   = 7'h16;
    localparam opc_t OP_SUM_SH   = 7'h17;
    localparam opc_t OP_SLLW     = 7'h18;
    localparam opc_t OP_SRLW     = 7'h19;
    localparam opc_t OP_SRAW     = 7'h1A;
    localparam opc_t OP_ROTLW    = 7'h1C;
    localparam opc_t OP_ROTRW    = 7'h1D;

    // add family
    localparam opc_t OP_ADD_UW   = 7'h20;
    localparam opc_t OP_ADD      = 7'h21;
    localparam opc_t OP_ODDADD   = 7'h22;
    localparam opc_t OP_R29_ADD  = 7'h24;
    localparam opc_t OP_R30_ADD  = 7'h25;
    localparam opc_t OP_R31_ADD  = 7'h26;
    localparam opc_t OP_R32_ADD  = 7'h27;
    localparam opc_t OP_L1_ADDUW = 7'h28;
    localparam opc_t OP_L1_ADD   = 7'h29;
    localparam opc_t OP_L2_ADDUW = 7'h2A;
    localparam opc_t OP_L2_ADD   = 7'h2B;
    localparam opc_t OP_L3_ADDUW = 7'h2C;
    localparam opc_t OP_L3_ADD   = 7'h2D;
    localparam opc_t OP_L4_ADD   = 7'h2F;

    // subtract and compare family
    localparam opc_t OP_SUB      = 7'h30;
    localparam opc_t OP_LTU      = 7'h31;
    localparam opc_t OP_LTS      = 7'h32;
    localparam opc_t OP_MAXU     = 7'h34;
    localparam opc_t OP_MINU     = 7'h35;
    localparam opc_t OP_MAXS     = 7'h36;
    localparam opc_t OP_MINS     = 7'h37;

    // logic family
    localparam opc_t OP_AND      = 7'h40;
    localparam opc_t OP_ANDNOT   = 7'h41;
    localparam opc_t OP_OR       = 7'h42;
    localparam opc_t OP_ORNOT    = 7'h43;
    localparam opc_t OP_XOR      = 7'h44;
    localparam opc_t OP_XNOR     = 7'h45;
    localparam opc_t OP_BSPREAD  = 7'h46;

    // branch comparison kinds, opcode bits [3:2]
    localparam logic [1:0] BR_EQ  = 2'b00;
    localparam logic [1:0] BR_LTS = 2'b10;
    localparam logic [1:0] BR_LTU = 2'b11;

endpackage

// File: rtl/ix_alu_shift.sv
module ix_alu_shift
    import ix_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  opc_t                      op,
    input  logic [DATA_W-1:0]         a,
    input  logic [$clog2(DATA_W)-1:0] amt,
    output logic [DATA_W-1:0]         res
);
    localparam int SH_W  = $clog2(DATA_W);
    localparam int WSH_W = $clog2(WORD_W);

    logic [2*DATA_W-1:0] dbl;
    logic [2*WORD_W-1:0] wdbl;
    logic [WORD_W-1:0]   wres;
    logic [WSH_W-1:0]    wamt;
    logic [DATA_W-1:0]   onehot;

    function automatic logic [DATA_W-1:0] sext_w(input logic [WORD_W-1:0] w);
        return {{(DATA_W-WORD_W){w[WORD_W-1]}}, w};
    endfunction

    always_comb begin
        wamt   = amt[WSH_W-1:0];
        onehot = DATA_W'(1) << amt;
        dbl    = '0;
        wdbl   = '0;
        wres   = '0;
        res    = '0;
        case (op)
            OP_SLL_UW: res = DATA_W'(a[WORD_W-1:0]) << amt;
            OP_SLL:    res = a << amt;
            OP_SRL:    res = a >> amt;
            OP_SRA:    res = DATA_W'($signed(a) >>> amt);
            OP_ROTL: begin
                dbl = {a, a} << amt;
                res = dbl[2*DATA_W-1:DATA_W];
            end
            OP_ROTR: begin
                dbl = {a, a} >> amt;
                res = dbl[DATA_W-1:0];
            end
            OP_BITCLR: res = a & ~onehot;
            OP_BITSET: res = a | onehot;
            OP_BITGET: res = DATA_W'(a[amt]);
            OP_SLLW: begin
                wres = a[WORD_W-1:0] << wamt;
                res  = sext_w(wres);
            end
            OP_SRLW: begin
                wres = a[WORD_W-1:0] >> wamt;
                res  = sext_w(wres);
            end
            OP_SRAW: begin
                wres = WORD_W'($signed(a[WORD_W-1:0]) >>> wamt);
                res  = sext_w(wres);
            end
            OP_ROTLW: begin
                wdbl = {a[WORD_W-1:0], a[WORD_W-1:0]} << wamt;
                res  = sext_w(wdbl[2*WORD_W-1:WORD_W]);
            end
            OP_ROTRW: begin
                wdbl = {a[WORD_W-1:0], a[WORD_W-1:0]} >> wamt;
                res  = sext_w(wdbl[WORD_W-1:0]);
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/ix_alu_arith.sv
module ix_alu_arith
    import ix_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  opc_t              op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              taken
);
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;

    logic [DATA_W-1:0] sum, diff, odd_sum, a_uw;
    logic              eq, lt_s, lt_u, br_kind_ok, br_cond;

    function automatic logic [DATA_W-1:0] sext_w(input logic [WORD_W-1:0] w);
        return {{(DATA_W-WORD_W){w[WORD_W-1]}}, w};
    endfunction

    always_comb begin
        sum     = a + b;
        diff    = a - b;
        odd_sum = DATA_W'(a[0]) + b;
        a_uw    = DATA_W'(a[WORD_W-1:0]);
        eq      = (a == b);
        lt_s    = ($signed(a) < $signed(b));
        lt_u    = (a < b);

        case (op)
            OP_ADDW:     res = sext_w(sum[WORD_W-1:0]);
            OP_ODDADDW:  res = sext_w(odd_sum[WORD_W-1:0]);
            OP_SUBW:     res = sext_w(diff[WORD_W-1:0]);
            OP_SUM_BIT:  res = DATA_W'(sum[0]);
            OP_SUM_BYTE: res = DATA_W'(sum[BYTE_W-1:0]);
            OP_SUM_ZH:   res = DATA_W'(sum[HALF_W-1:0]);
            OP_SUM_SH:   res = {{(DATA_W-HALF_W){sum[HALF_W-1]}}, sum[HALF_W-1:0]};
            OP_ADD_UW:   res = a_uw + b;
            OP_ADD:      res = sum;
            OP_ODDADD:   res = odd_sum;
            OP_R29_ADD:  res = (a >> 29) + b;
            OP_R30_ADD:  res = (a >> 30) + b;
            OP_R31_ADD:  res = (a >> 31) + b;
            OP_R32_ADD:  res = (a >> 32) + b;
            OP_L1_ADDUW: res = (a_uw << 1) + b;
            OP_L1_ADD:   res = (a << 1) + b;
            OP_L2_ADDUW: res = (a_uw << 2) + b;
            OP_L2_ADD:   res = (a << 2) + b;
            OP_L3_ADDUW: res = (a_uw << 3) + b;
            OP_L3_ADD:   res = (a << 3) + b;
            OP_L4_ADD:   res = (a << 4) + b;
            OP_SUB:      res = diff;
            OP_LTU:      res = DATA_W'(lt_u);
            OP_LTS:      res = DATA_W'(lt_s);
            OP_MAXU:     res = lt_u ? b : a;
            OP_MINU:     res = lt_u ? a : b;
            OP_MAXS:     res = lt_s ? b : a;
            OP_MINS:     res = lt_s ? a : b;
            default:     res = '0;
        endcase

        // branch condition: kind in [3:2], invert in [1], [0] must be clear
        br_kind_ok = 1'b0;
        br_cond    = 1'b0;
        if (op[6:4] == FAM_BR && !op[0]) begin
            case (op[3:2])
                BR_EQ:   begin br_kind_ok = 1'b1; br_cond = eq;   end
                BR_LTS:  begin br_kind_ok = 1'b1; br_cond = lt_s; end
                BR_LTU:  begin br_kind_ok = 1'b1; br_cond = lt_u; end
                default: begin br_kind_ok = 1'b0; br_cond = 1'b0; end
            endcase
        end
        taken = br_kind_ok & (br_cond ^ op[1]);
    end

endmodule

// File: rtl/ix_alu_logic.sv
module ix_alu_logic
    import ix_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  opc_t              op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    localparam int NBYTES = DATA_W / 8;
    localparam int HALF_W = 16;

    logic [DATA_W-1:0] spread, base;

    // every nonzero byte becomes all ones
    for (genvar g = 0; g < NBYTES; g++) begin : g_spread
        assign spread[8*g +: 8] = {8{|a[8*g +: 8]}};
    end

    always_comb begin
        case (op[2:1])
            2'b00:   base = a & b;
            2'b01:   base = a | b;
            2'b10:   base = a ^ b;
            default: base = spread;
        endcase

        res = '0;
        if (op[6:4] == FAM_NARLG && !op[3]) begin
            res = op[0] ? DATA_W'(base[HALF_W-1:0]) : DATA_W'(base[0]);
        end else begin
            case (op)
                OP_AND:     res = a & b;
                OP_ANDNOT:  res = a & ~b;
                OP_OR:      res = a | b;
                OP_ORNOT:   res = a | ~b;
                OP_XOR:     res = a ^ b;
                OP_XNOR:    res = ~(a ^ b);
                OP_BSPREAD: res = spread;
                default:    res = '0;
            endcase
        end
    end

endmodule

// File: rtl/ix_alu.sv
module ix_alu
    import ix_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [6:0]        in_op,
    input  logic [DATA_W-1:0] in_src1,
    input  logic [DATA_W-1:0] in_src2,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_taken
);
    localparam int SH_W = $clog2(DATA_W);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] res;
        logic              taken;
    } stage_t;

    stage_t            stage_d, stage_q;
    logic [DATA_W-1:0] shf_res, ari_res, log_res;
    logic              ari_taken;

    ix_alu_shift #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_shift (
        .op  (in_op),
        .a   (in_src1),
        .amt (in_src2[SH_W-1:0]),
        .res (shf_res)
    );

    ix_alu_arith #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_arith (
        .op    (in_op),
        .a     (in_src1),
        .b     (in_src2),
        .res   (ari_res),
        .taken (ari_taken)
    );

    ix_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .op  (in_op),
        .a   (in_src1),
        .b   (in_src2),
        .res (log_res)
    );

    // each datapath returns zero for opcodes it does not own
    always_comb begin
        stage_d       = '0;
        stage_d.valid = in_valid;
        if (in_valid) begin
            stage_d.res   = shf_res | ari_res | log_res;
            stage_d.taken = ari_taken;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid  = stage_q.valid;
    assign out_result = stage_q.res;
    assign out_taken  = stage_q.taken;

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_result == '0 && !out_taken));

    // R11
    taken_only_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[6:4] != FAM_BR) |=> !out_taken);

    // R11
    branch_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[6:4] == FAM_BR) |=> out_result == '0);

    // R4
    word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[6:4] == FAM_WORD && in_op[3:2] != 2'b01)
        |=> out_result[DATA_W-1:WORD_W] == {(DATA_W-WORD_W){out_result[WORD_W-1]}});

    // R3
    bitget_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_BITGET) |=> out_result[DATA_W-1:1] == '0);

    // R12
    rsvd_family_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[6:4] == FAM_RSVD) |=> (out_result == '0 && !out_taken));

    // R12
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|shf_res, |ari_res, |log_res}));

endmodule

// File: tb/ix_alu_test.sv
module ix_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [6:0]  in_op = '0;
    logic [63:0] in_src1 = '0;
    logic [63:0] in_src2 = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_taken;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ix_alu uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_src1    (in_src1),
        .in_src2    (in_src2),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_taken  (out_taken)
    );

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
    localparam logic [63:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;

    // {op, src1, src2, expected result, expected taken}
    localparam int NTAB = 25;
    localparam logic [199:0] TAB [NTAB] = '{
        {7'h21, 64'd5, 64'd7, 64'd12, 1'b0},
        {7'h30, 64'd3, 64'd5, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0},
        {7'h32, ONES, 64'd1, 64'd1, 1'b0},
        {7'h31, ONES, 64'd1, 64'd0, 1'b0},
        {7'h10, 64'h7FFF_FFFF, 64'd1, 64'hFFFF_FFFF_8000_0000, 1'b0},
        {7'h1A, 64'h8000_0000, 64'd4, 64'hFFFF_FFFF_F800_0000, 1'b0},
        {7'h19, 64'hFFFF_FFFF_8000_0000, 64'd4, 64'h0800_0000, 1'b0},
        {7'h2B, 64'd3, 64'd1, 64'd13, 1'b0},
        {7'h28, 64'hFFFF_FFFF_0000_0001, 64'd0, 64'd2, 1'b0},
        {7'h27, 64'h5_0000_0000, 64'd1, 64'd6, 1'b0},
        {7'h15, 64'hFF, 64'd2, 64'd1, 1'b0},
        {7'h17, 64'h7FFF, 64'd1, 64'hFFFF_FFFF_FFFF_8000, 1'b0},
        {7'h03, 64'd0, 64'd63, MINV, 1'b0},
        {7'h06, MINV, 64'd63, 64'd1, 1'b0},
        {7'h0B, 64'd1, 64'd1, MINV, 1'b0},
        {7'h1C, 64'h8000_0000, 64'd1, 64'd1, 1'b0},
        {7'h43, 64'd0, ONES, 64'd0, 1'b0},
        {7'h65, 64'hFFFF_FFFF, 64'h0F0F_0000, 64'hFFFF, 1'b0},
        {7'h46, 64'h0100_0000_0000_0080, 64'd0, 64'hFF00_0000_0000_00FF, 1'b0},
        {7'h78, ONES, 64'd0, 64'd0, 1'b1},
        {7'h37, ONES, 64'd1, ONES, 1'b0},
        {7'h7E, ONES, 64'd0, 64'd0, 1'b1},
        {7'h34, ONES, 64'd1, ONES, 1'b0},
        {7'h72, 64'd4, 64'd4, 64'd0, 1'b0},
        {7'h50, ONES, ONES, 64'd0, 1'b0}
    };

    function automatic logic [63:0] sx32(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    function automatic logic [63:0] spread_ref(input logic [63:0] x);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = (x[8*i +: 8] != 8'h00) ? 8'hFF : 8'h00;
        return r;
    endfunction

    // independent reference: {listed, taken, result}
    function automatic logic [65:0] model(input logic [6:0] op, input logic [63:0] a,
                                          input logic [63:0] b);
        logic [63:0] r, s, z, x;
        logic [31:0] w;
        logic        t, ok;
        int          sh, wsh;
        r = '0; t = 1'b0; ok = 1'b1;
        s = a + b;
        z = {32'h0, a[31:0]};
        sh = int'(b[5:0]);
        wsh = int'(b[4:0]);
        w = a[31:0];
        case (op)
            7'h00: r = z << sh;
            7'h01: r = a << sh;
            7'h02: r = a & ~(64'h1 << sh);
            7'h03: r = a | (64'h1 << sh);
            7'h05: r = a >> sh;
            7'h06: r = {63'h0, a[sh]};
            7'h07: r = 64'($signed(a) >>> sh);
            7'h09: r = (sh == 0) ? a : ((a << sh) | (a >> (64 - sh)));
            7'h0B: r = (sh == 0) ? a : ((a >> sh) | (a << (64 - sh)));
            7'h10: r = sx32(a[31:0] + b[31:0]);
            7'h11: r = sx32(32'(a[0]) + b[31:0]);
            7'h12: r = sx32(a[31:0] - b[31:0]);
            7'h14: r = {63'h0, s[0]};
            7'h15: r = {56'h0, s[7:0]};
            7'h16: r = {48'h0, s[15:0]};
            7'h17: r = {{48{s[15]}}, s[15:0]};
            7'h18: r = sx32(w << wsh);
            7'h19: r = sx32(w >> wsh);
            7'h1A: r = sx32(32'($signed(w) >>> wsh));
            7'h1C: r = sx32((wsh == 0) ? w : ((w << wsh) | (w >> (32 - wsh))));
            7'h1D: r = sx32((wsh == 0) ? w : ((w >> wsh) | (w << (32 - wsh))));
            7'h20: r = z + b;
            7'h21: r = s;
            7'h22: r = {63'h0, a[0]} + b;
            7'h24: r = (a >> 29) + b;
            7'h25: r = (a >> 30) + b;
            7'h26: r = (a >> 31) + b;
            7'h27: r = (a >> 32) + b;
            7'h28: r = (z << 1) + b;
            7'h29: r = (a << 1) + b;
            7'h2A: r = (z << 2) + b;
            7'h2B: r = (a << 2) + b;
            7'h2C: r = (z << 3) + b;
            7'h2D: r = (a << 3) + b;
            7'h2F: r = (a << 4) + b;
            7'h30: r = a - b;
            7'h31: r = {63'h0, a < b};
            7'h32: r = {63'h0, $signed(a) < $signed(b)};
            7'h34: r = (a > b) ? a : b;
            7'h35: r = (a < b) ? a : b;
            7'h36: r = ($signed(a) > $signed(b)) ? a : b;
            7'h37: r = ($signed(a) < $signed(b)) ? a : b;
            7'h40: r = a & b;
            7'h41: r = a & ~b;
            7'h42: r = a | b;
            7'h43: r = a | ~b;
            7'h44: r = a ^ b;
            7'h45: r = a ~^ b;
            7'h46: r = spread_ref(a);
            7'h60, 7'h61, 7'h62, 7'h63, 7'h64, 7'h65, 7'h66, 7'h67: begin
                case (op[2:1])
                    2'd0: x = a & b;
                    2'd1: x = a | b;
                    2'd2: x = a ^ b;
                    default: x = spread_ref(a);
                endcase
                r = op[0] ? {48'h0, x[15:0]} : {63'h0, x[0]};
            end
            7'h70: t = (a == b);
            7'h72: t = (a != b);
            7'h78: t = ($signed(a) < $signed(b));
            7'h7A: t = ($signed(a) >= $signed(b));
            7'h7C: t = (a < b);
            7'h7E: t = (a >= b);
            default: ok = 1'b0;
        endcase
        return {ok, t, r};
    endfunction

    function automatic string tag_of(input logic [6:0] op, input logic listed);
        if (!listed) return "R12";
        case (op[6:4])
            3'b000: return (op == 7'h02 || op == 7'h03 || op == 7'h06) ? "R3" : "R2";
            3'b001: return (op[3:2] == 2'b01 || op == 7'h11) ? "R5" : "R4";
            3'b010: return op[3] ? "R7" : "R6";
            3'b011: return "R8";
            3'b100: return "R9";
            3'b110: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic ev, input logic [63:0] er,
                         input logic et);
        n_vec++;
        if (out_valid !== ev || out_result !== er || out_taken !== et) begin
            n_bad++;
            $display("FAIL %s: actual valid=%0b result=%h taken=%0b, expected valid=%0b result=%h taken=%0b",
                     tag, out_valid, out_result, out_taken, ev, er, et);
        end
    endtask

    // drive on the falling edge, sample 1 ns after the next rising edge
    task automatic issue(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] er, input logic et, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_src1 = a; in_src2 = b;
        @(posedge clk);
        #1;
        check(tag, 1'b1, er, et);
    endtask

    task automatic issue_model(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [65:0] m;
        m = model(op, a, b);
        issue(op, a, b, m[63:0], m[64], tag_of(op, m[65]));
    endtask

    task automatic idle(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b0; in_op = op; in_src1 = a; in_src2 = b;
        @(posedge clk);
        #1;
        check("R1 idle", 1'b0, 64'd0, 1'b0);   // R1
    endtask

    function automatic logic [63:0] pick_a(input int k);
        case (k % 6)
            0: return 64'd0;
            1: return ONES;
            2: return MINV;
            3: return MAXV;
            4: return {$urandom, $urandom};
            default: return {32'h0, $urandom};
        endcase
    endfunction

    function automatic logic [63:0] pick_b(input int k);
        case (k % 7)
            0: return 64'd63;
            1: return 64'd31;
            2: return 64'd32;
            3: return MINV;
            4: return 64'd0;
            5: return {$urandom, $urandom};
            default: return ONES;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [199:0] v;
        // R1: reset state, even with a taken branch presented
        in_valid = 1'b1; in_op = 7'h70; in_src1 = 64'd9; in_src2 = 64'd9;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 1'b0, 64'd0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after reset", 1'b0, 64'd0, 1'b0);

        // table walk, back to back
        for (int i = 0; i < NTAB; i++) begin
            v = TAB[i];
            issue(v[199:193], v[192:129], v[128:65], v[64:1], v[0],
                  tag_of(v[199:193], model(v[199:193], 64'd0, 64'd0) >> 65 != 0));
        end

        // R1: idle cycles suppress a would-be taken branch and a nonzero sum
        idle(7'h70, 64'd1, 64'd1);
        idle(7'h21, ONES, ONES);

        // R11: taken branch followed at once by a nonzero result
        issue(7'h7C, 64'd1, 64'd2, 64'd0, 1'b1, "R11 bltu taken");
        issue(7'h21, 64'd1, 64'd2, 64'd3, 1'b0, "R11 add after branch");
        issue(7'h7A, MINV, 64'd0, 64'd0, 1'b0, "R11 bge most-negative");
        issue(7'h74, 64'd0, 64'd0, 64'd0, 1'b0, "R12 unlisted branch kind");

        // R2/R4 corners: maximum amounts and most negative value
        issue(7'h07, MINV, 64'd63, ONES, 1'b0, "R2 sra by 63");
        issue(7'h09, MINV, 64'hFFC0, MINV, 1'b0, "R2 rol amount bits above [5:0] ignored");
        issue(7'h1A, MINV, 64'd31, 64'd0, 1'b0, "R4 sraw ignores upper word");
        issue(7'h18, 64'd1, 64'd63, MINV >> 32 | ONES << 32, 1'b0, "R4 sllw uses [4:0]");
        issue(7'h36, MINV, MAXV, MAXV, 1'b0, "R8 max signed extreme");
        issue(7'h35, MINV, MAXV, MAXV, 1'b0, "R8 minu extreme");
        issue(7'h22, ONES, 64'd5, 64'd6, 1'b0, "R6 odd add");
        issue(7'h2F, MINV | 64'd1, 64'd0, 64'd16, 1'b0, "R7 scale by 16");
        issue(7'h60, 64'd3, 64'd1, 64'd1, 1'b0, "R10 and keep bit 0");
        issue(7'h14, 64'd1, 64'd1, 64'd0, 1'b0, "R5 sum bit");

        // every opcode with corner and random operands against the model
        for (int op = 0; op < 128; op++) begin
            for (int k = 0; k < 8; k++) begin
                issue_model(7'(op), pick_a(k + op), pick_b(k));
            end
        end

        idle(7'h00, 64'd0, 64'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule